// File: doc/BRIEF.md
# Banked Stack Pointer with Packed FP Status

This block is a small slice of a processor register file. It keeps two stack pointers: a 64-bit user pointer and a supervisor pointer that only stores 48 bits. The top 16 bits of the user pointer hold the floating-point status field. There is no separate status register. Reads are combinational and go through a register index. Writes happen on the clock edge through a second index.

A two-state mode machine follows interrupt service. The states are `MODE_USER` and `MODE_HANDLER`. The transition `USER->HANDLER` fires on the cycle after an enter strobe, and `HANDLER->USER` fires on the cycle after a return strobe. While in `MODE_HANDLER`, the stack-pointer index and the supervisor index swap targets. This lets handler code use the normal stack-pointer index for its own stack. It also makes sure that nothing the handler does can change the status bits the user program sees.

The FPU reports new exception flags through a separate strobe. In user mode these flags accumulate into the status field. In handler mode they are dropped.

Top module: `stkptr_bank`

## Requirements
- R1: After reset both pointers and the status field read as zero, and `in_handler_o` is 0.
- R2: An `irq_enter_i` pulse in user mode sets `in_handler_o`, and routing changes, from the next cycle onward. An `irq_return_i` pulse in handler mode clears it in the same way. An enter pulse in handler mode is ignored, and a return pulse in user mode is ignored.
- R3: In user mode, index 15 reads and writes the whole 64-bit user register. Index 27 reaches the supervisor register.
- R4: In handler mode, index 15 reaches the supervisor register and index 27 reads the whole 64-bit user register.
- R5: The supervisor register keeps only bits 47:0. Its bits 63:48 always read zero, and data written to them is discarded.
- R6: Index 28 reads the user register bits 63:48 in `rd_data_o[15:0]`, with all upper bits zero, in either mode. In user mode a write to index 28 replaces only user bits 63:48, taking the value from `wr_data_i[15:0]`.
- R7: Index 29 is a pointer-only view of the register that index 15 currently reaches. It reads bits 47:0 zero-extended, and a write changes only bits 47:0.
- R8: In user mode, `fpu_flags_i` is ORed into user bits 63:48 when `fpu_flag_valid_i` is high. A status bit never clears except by a register write.
- R9: In handler mode, FPU flag updates are ignored.
- R10: A write that targets the status bits wins over an FPU update in the same cycle. A write to index 15 in user mode or to index 28 targets the status bits. A pointer-only write does not block the same-cycle update.
- R11: In handler mode, user bits 63:48 never change. A write to index 28 is ignored, and a write through index 27 changes only bits 47:0. The status value at return therefore equals the value at entry.
- R12: Every other index reads zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_enter_i | input | 1 | Single-cycle strobe: interrupt service begins |
| irq_return_i | input | 1 | Single-cycle strobe: interrupt service ends |
| rd_idx_i | input | 5 | Read register index |
| rd_data_o | output | 64 | Read data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Write register index |
| wr_data_i | input | 64 | Write data |
| fpu_flag_valid_i | input | 1 | FPU flag update strobe |
| fpu_flags_i | input | 16 | Flags to accumulate into the status field |
| in_handler_o | output | 1 | High while the handler mode is active |

## Verification
The hardest condition to reach is a handler that tries every path into the status bits while the user pointer is being rewritten through the swapped index. The test has to combine a swapped full write, an alias write and an FPU strobe, all in handler mode, and then check at return that the status value seen at entry has survived. The test also loads a distinct non-zero status value first, using both alias writes and sticky FPU updates. This way a leak of any one of those paths shows up as a changed bit pattern. Same-cycle write-versus-FPU collisions are driven on purpose, on both the status alias and the pointer-only view.

// File: rtl/spb_pkg.sv
package spb_pkg;

    typedef enum logic [0:0] {
        MODE_USER    = 1'b0,
        MODE_HANDLER = 1'b1
    } spb_mode_e;

    // physical destination of an access after mode steering
    typedef enum logic [2:0] {
        TGT_NONE     = 3'd0,
        TGT_USR_FULL = 3'd1,
        TGT_USR_PTR  = 3'd2,
        TGT_USR_STAT = 3'd3,
        TGT_SUP      = 3'd4
    } spb_tgt_e;

endpackage

// File: rtl/spb_mode_fsm.sv
module spb_mode_fsm
    import spb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enter_i,
    input  logic      return_i,
    output logic      handler_o
);

    spb_mode_e state_q;
    spb_mode_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_USER:    if (enter_i)  state_d = MODE_HANDLER;
            MODE_HANDLER: if (return_i) state_d = MODE_USER;
            default:                    state_d = MODE_USER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_USER;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MODE_HANDLER: handler_o = 1'b1;
            default:      handler_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/spb_route.sv
module spb_route
    import spb_pkg::*;
#(
    parameter int          IDX_W     = 5,
    parameter logic [4:0]  IDX_SP    = 5'd15,
    parameter logic [4:0]  IDX_SSP   = 5'd27,
    parameter logic [4:0]  IDX_STAT  = 5'd28,
    parameter logic [4:0]  IDX_PTR   = 5'd29,
    parameter bit          FOR_WRITE = 1'b0
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             handler_i,
    output spb_tgt_e         tgt_o
);

    generate
        if (FOR_WRITE) begin : g_wr
            // write steering: the handler can never reach the status bits
            always_comb begin
                tgt_o = TGT_NONE;
                if (idx_i == IDX_W'(IDX_SP))
                    tgt_o = handler_i ? TGT_SUP : TGT_USR_FULL;
                else if (idx_i == IDX_W'(IDX_SSP))
                    tgt_o = handler_i ? TGT_USR_PTR : TGT_SUP;
                else if (idx_i == IDX_W'(IDX_STAT))
                    tgt_o = handler_i ? TGT_NONE : TGT_USR_STAT;
                else if (idx_i == IDX_W'(IDX_PTR))
                    tgt_o = handler_i ? TGT_SUP : TGT_USR_PTR;
            end
        end else begin : g_rd
            always_comb begin
                tgt_o = TGT_NONE;
                if (idx_i == IDX_W'(IDX_SP))
                    tgt_o = handler_i ? TGT_SUP : TGT_USR_FULL;
                else if (idx_i == IDX_W'(IDX_SSP))
                    tgt_o = handler_i ? TGT_USR_FULL : TGT_SUP;
                else if (idx_i == IDX_W'(IDX_STAT))
                    tgt_o = TGT_USR_STAT;
                else if (idx_i == IDX_W'(IDX_PTR))
                    tgt_o = handler_i ? TGT_SUP : TGT_USR_PTR;
            end
        end
    endgenerate

endmodule

// File: rtl/spb_store.sv
module spb_store
    import spb_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int PTR_W = 48
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   handler_i,
    input  logic                   wr_en_i,
    input  spb_tgt_e               wr_tgt_i,
    input  logic [XLEN-1:0]        wr_data_i,
    input  logic                   fpu_valid_i,
    input  logic [XLEN-PTR_W-1:0]  fpu_flags_i,
    output logic [XLEN-1:0]        usr_q_o,
    output logic [PTR_W-1:0]       sup_q_o
);

    localparam int STAT_W = XLEN - PTR_W;

    logic [XLEN-1:0]  usr_q, usr_d;
    logic [PTR_W-1:0] sup_q, sup_d;
    logic             stat_claimed;

    always_comb begin
        usr_d = usr_q;
        sup_d = sup_q;
        stat_claimed = wr_en_i &&
                       ((wr_tgt_i == TGT_USR_FULL) || (wr_tgt_i == TGT_USR_STAT));
        // sticky accumulation, user mode only, loses to a status write
        if (fpu_valid_i && !handler_i && !stat_claimed)
            usr_d[XLEN-1:PTR_W] = usr_q[XLEN-1:PTR_W] | fpu_flags_i;
        if (wr_en_i) begin
            unique case (wr_tgt_i)
                TGT_USR_FULL: usr_d = wr_data_i;
                TGT_USR_PTR:  usr_d[PTR_W-1:0] = wr_data_i[PTR_W-1:0];
                TGT_USR_STAT: usr_d[XLEN-1:PTR_W] = wr_data_i[STAT_W-1:0];
                TGT_SUP:      sup_d = wr_data_i[PTR_W-1:0];
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usr_q <= '0;
            sup_q <= '0;
        end else begin
            usr_q <= usr_d;
            sup_q <= sup_d;
        end
    end

    assign usr_q_o = usr_q;
    assign sup_q_o = sup_q;

endmodule

// File: rtl/stkptr_bank.sv
module stkptr_bank
    import spb_pkg::*;
#(
    parameter int          XLEN     = 64,
    parameter int          PTR_W    = 48,
    parameter int          IDX_W    = 5,
    parameter logic [4:0]  IDX_SP   = 5'd15,
    parameter logic [4:0]  IDX_SSP  = 5'd27,
    parameter logic [4:0]  IDX_STAT = 5'd28,
    parameter logic [4:0]  IDX_PTR  = 5'd29
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   irq_enter_i,
    input  logic                   irq_return_i,
    input  logic [IDX_W-1:0]       rd_idx_i,
    output logic [XLEN-1:0]        rd_data_o,
    input  logic                   wr_en_i,
    input  logic [IDX_W-1:0]       wr_idx_i,
    input  logic [XLEN-1:0]        wr_data_i,
    input  logic                   fpu_flag_valid_i,
    input  logic [XLEN-PTR_W-1:0]  fpu_flags_i,
    output logic                   in_handler_o
);

    localparam int STAT_W = XLEN - PTR_W;

    logic             handler;
    spb_tgt_e         rd_tgt, wr_tgt;
    logic [XLEN-1:0]  usr_q;
    logic [PTR_W-1:0] sup_q;

    spb_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_i   (irq_enter_i),
        .return_i  (irq_return_i),
        .handler_o (handler)
    );

    spb_route #(
        .IDX_W(IDX_W), .IDX_SP(IDX_SP), .IDX_SSP(IDX_SSP),
        .IDX_STAT(IDX_STAT), .IDX_PTR(IDX_PTR), .FOR_WRITE(1'b0)
    ) u_rd_route (
        .idx_i     (rd_idx_i),
        .handler_i (handler),
        .tgt_o     (rd_tgt)
    );

    spb_route #(
        .IDX_W(IDX_W), .IDX_SP(IDX_SP), .IDX_SSP(IDX_SSP),
        .IDX_STAT(IDX_STAT), .IDX_PTR(IDX_PTR), .FOR_WRITE(1'b1)
    ) u_wr_route (
        .idx_i     (wr_idx_i),
        .handler_i (handler),
        .tgt_o     (wr_tgt)
    );

    spb_store #(.XLEN(XLEN), .PTR_W(PTR_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .handler_i   (handler),
        .wr_en_i     (wr_en_i),
        .wr_tgt_i    (wr_tgt),
        .wr_data_i   (wr_data_i),
        .fpu_valid_i (fpu_flag_valid_i),
        .fpu_flags_i (fpu_flags_i),
        .usr_q_o     (usr_q),
        .sup_q_o     (sup_q)
    );

    always_comb begin
        unique case (rd_tgt)
            TGT_USR_FULL: rd_data_o = usr_q;
            TGT_USR_PTR:  rd_data_o = {{STAT_W{1'b0}}, usr_q[PTR_W-1:0]};
            TGT_USR_STAT: rd_data_o = {{PTR_W{1'b0}}, usr_q[XLEN-1:PTR_W]};
            TGT_SUP:      rd_data_o = {{STAT_W{1'b0}}, sup_q};
            default:      rd_data_o = '0;
        endcase
    end

    assign in_handler_o = handler;

endmodule

// File: rtl/spb_checker.sv
module spb_checker #(
    parameter int          XLEN     = 64,
    parameter int          PTR_W    = 48,
    parameter int          IDX_W    = 5,
    parameter logic [4:0]  IDX_SP   = 5'd15,
    parameter logic [4:0]  IDX_STAT = 5'd28
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq_enter_i,
    input logic                irq_return_i,
    input logic                in_handler_o,
    input logic                wr_en_i,
    input logic [IDX_W-1:0]    rd_idx_i,
    input logic [XLEN-1:0]     rd_data_o,
    input logic [XLEN-1:0]     usr_q
);

    a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enter_i && !in_handler_o) |=> in_handler_o);

    a_r2_return: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return_i && in_handler_o) |=> !in_handler_o);

    a_r5_sup_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler_o && rd_idx_i == IDX_W'(IDX_SP)) |-> (rd_data_o[XLEN-1:PTR_W] == '0));

    a_r6_alias_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_i == IDX_W'(IDX_STAT)) |->
        (rd_data_o == {{PTR_W{1'b0}}, usr_q[XLEN-1:PTR_W]}));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler_o && !wr_en_i) |=>
        (($past(usr_q[XLEN-1:PTR_W]) & ~usr_q[XLEN-1:PTR_W]) == '0));

    a_r11_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        in_handler_o |=> $stable(usr_q[XLEN-1:PTR_W]));

endmodule

bind stkptr_bank spb_checker #(
    .XLEN(XLEN), .PTR_W(PTR_W), .IDX_W(IDX_W),
    .IDX_SP(IDX_SP), .IDX_STAT(IDX_STAT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_enter_i  (irq_enter_i),
    .irq_return_i (irq_return_i),
    .in_handler_o (in_handler_o),
    .wr_en_i      (wr_en_i),
    .rd_idx_i     (rd_idx_i),
    .rd_data_o    (rd_data_o),
    .usr_q        (usr_q)
);

// File: tb/tb_stkptr_bank.sv
module tb_stkptr_bank;

    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] I_SP = 5'd15, I_SSP = 5'd27, I_ST = 5'd28, I_PT = 5'd29;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_enter = 1'b0, irq_return = 1'b0;
    logic [4:0]  rd_idx = '0, wr_idx = '0;
    logic [63:0] rd_data, wr_data = '0;
    logic        wr_en = 1'b0, fpu_v = 1'b0;
    logic [15:0] fpu_f = '0;
    logic        in_handler;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stkptr_bank dut (
        .clk(clk), .rst_n(rst_n),
        .irq_enter_i(irq_enter), .irq_return_i(irq_return),
        .rd_idx_i(rd_idx), .rd_data_o(rd_data),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .fpu_flag_valid_i(fpu_v), .fpu_flags_i(fpu_f),
        .in_handler_o(in_handler)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [4:0] idx, input string tag, input logic [63:0] exp);
        rd_idx = idx;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [4:0] idx, input logic [63:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fpu(input logic [15:0] f);
        fpu_v = 1'b1; fpu_f = f;
        @(negedge clk);
        fpu_v = 1'b0; fpu_f = '0;
    endtask

    task automatic pulse(input bit is_enter);
        if (is_enter) irq_enter = 1'b1; else irq_return = 1'b1;
        @(negedge clk);
        irq_enter = 1'b0; irq_return = 1'b0;
    endtask

    task automatic t_reset;
        rd(I_SP,  "R1 sp", 64'h0);
        rd(I_SSP, "R1 ssp", 64'h0);
        rd(I_ST,  "R1 status", 64'h0);
        check("R1 mode", {63'h0, in_handler}, 64'h0);
    endtask

    task automatic t_user_access;
        wr(I_SP, 64'hA5A5_1234_5678_9ABC);
        rd(I_SP, "R3 sp full", 64'hA5A5_1234_5678_9ABC);
        rd(I_ST, "R6 alias read", 64'h0000_0000_0000_A5A5);
        rd(I_PT, "R7 ptr read", 64'h0000_1234_5678_9ABC);
        wr(I_SSP, 64'hFFFF_0000_1111_2222);
        rd(I_SSP, "R3 R5 ssp user", 64'h0000_0000_1111_2222);
    endtask

    task automatic t_ptr_and_alias;
        wr(I_PT, 64'h0BAD_0000_0000_4000);
        rd(I_SP, "R7 ptr write keeps status", 64'hA5A5_0000_0000_4000);
        wr(I_ST, 64'hFFFF_FFFF_FFFF_00C3);
        rd(I_SP, "R6 alias write", 64'h00C3_0000_0000_4000);
    endtask

    task automatic t_fpu_sticky;
        fpu(16'h0100);
        rd(I_ST, "R8 or in", 64'h01C3);
        fpu(16'h0003);
        rd(I_ST, "R8 sticky", 64'h01C3);
    endtask

    task automatic t_priority;
        wr_en = 1'b1; wr_idx = I_ST; wr_data = 64'h0010;
        fpu_v = 1'b1; fpu_f = 16'h8000;
        @(negedge clk);
        wr_en = 1'b0; fpu_v = 1'b0;
        rd(I_ST, "R10 write wins", 64'h0010);
        wr_en = 1'b1; wr_idx = I_PT; wr_data = 64'h7000;
        fpu_v = 1'b1; fpu_f = 16'h0200;
        @(negedge clk);
        wr_en = 1'b0; fpu_v = 1'b0;
        rd(I_SP, "R10 ptr write and fpu", 64'h0210_0000_0000_7000);
    endtask

    task automatic t_enter;
        irq_enter = 1'b1;
        rd(I_SP, "R2 no swap in strobe cycle", 64'h0210_0000_0000_7000);
        check("R2 mode during strobe", {63'h0, in_handler}, 64'h0);
        @(negedge clk);
        irq_enter = 1'b0;
        check("R2 entered", {63'h0, in_handler}, 64'h1);
        rd(I_SP,  "R4 sp to sup", 64'h0000_0000_1111_2222);
        rd(I_SSP, "R4 ssp to user", 64'h0210_0000_0000_7000);
    endtask

    task automatic t_handler;
        wr(I_SP, 64'hDEAD_0000_0000_8000);
        rd(I_SP, "R5 sup upper dropped", 64'h0000_0000_0000_8000);
        wr(I_SSP, 64'hEEEE_0000_0000_9000);
        rd(I_SSP, "R11 swapped write low only", 64'h0210_0000_0000_9000);
        wr(I_ST, 64'h1234);
        rd(I_ST, "R11 alias write ignored", 64'h0210);
        fpu(16'hFFFF);
        rd(I_ST, "R9 fpu ignored", 64'h0210);
        wr(I_PT, 64'hFFFF_0000_0000_A000);
        rd(I_PT, "R7 ptr view on sup", 64'h0000_0000_0000_A000);
        pulse(1'b1);
        check("R2 enter ignored in handler", {63'h0, in_handler}, 64'h1);
    endtask

    task automatic t_return;
        pulse(1'b0);
        check("R2 returned", {63'h0, in_handler}, 64'h0);
        rd(I_SP,  "R11 status kept at return", 64'h0210_0000_0000_9000);
        rd(I_SSP, "R3 ssp after return", 64'h0000_0000_0000_A000);
        pulse(1'b0);
        check("R2 return ignored in user", {63'h0, in_handler}, 64'h0);
    endtask

    task automatic t_unmapped;
        wr(5'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(5'd3, "R12 unmapped read", 64'h0);
        rd(I_SP, "R12 sp untouched", 64'h0210_0000_0000_9000);
        rd(I_SSP, "R12 ssp untouched", 64'h0000_0000_0000_A000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_user_access();
        t_ptr_and_alias();
        t_fpu_sticky();
        t_priority();
        t_enter();
        t_handler();
        t_return();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule